// File: doc/BRIEF.md
# Two-to-one SHA-256 pair hasher

This block reduces exactly one 64-byte message to its 32-byte SHA-256 digest. A typical message is two 32-byte child digests placed side by side when a parent node of a hash tree is built. The message arrives on one 512-bit bus with a valid/ready handshake. The digest leaves on a 256-bit bus together with a one-cycle valid strobe.

The length is fixed, so the final block of the hash never changes: a 0x80 marker, zeros, and the bit count 512. The block runs one compression over the message, with the message schedule expanded on the fly. It then runs a second compression over the constant final block. For that second pass, each round's sum of round constant and schedule word comes from a table built at elaboration time, so no schedule logic is active during that pass. Each pass executes one round per clock. A separate cycle after each pass folds the chaining value back in.

Top module: `pair_digest256`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_valid` is 0 and `out_digest` is all zeros.
- R2: A request is taken on a rising edge where both `in_valid` and `in_ready` are 1. From the next cycle, `in_ready` stays 0 until the cycle in which that request's digest is presented.
- R3: `out_valid` is 1 exactly 130 clock edges after the edge that took the request: 64 rounds, one fold, 64 rounds, one fold.
- R4: `out_valid` is high for a single cycle per taken request.
- R5: Message byte k (k = 0..63) sits on `in_msg[8k+7:8k]`. The digest equals SHA-256 of those 64 bytes in that order, and digest byte k is on `out_digest[8k+7:8k]`.
- R6: `in_valid` pulses and `in_msg` changes while `in_ready` is 0 have no effect on the digest of the request in flight.
- R7: `out_digest` changes only on the edge that raises `out_valid`, and holds its value until the next completion.
- R8: In the cycle where `out_valid` is 1, `in_ready` is already 1. A request offered in that cycle is taken and completes with the normal latency and a correct digest.
- R9: A reset during a hash abandons it: no `out_valid` follows it, and the block then hashes new requests correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offer |
| in_ready | output | 1 | High when idle and able to take a request |
| in_msg | input | 512 | 64 message bytes, byte k on bits 8k+7..8k |
| out_valid | output | 1 | One-cycle strobe for a new digest |
| out_digest | output | 256 | 32 digest bytes, byte k on bits 8k+7..8k |

## Verification
Completing a hash and taking the next request can happen in the same cycle, because `in_ready` rises together with `out_valid`. The bench provokes this by offering a new message exactly in the cycle where it sees the strobe. It then judges two things: the first digest must match the bench's reference, and the chained request must complete 130 edges later with its own correct digest. The bench also keeps `in_valid` asserted with changing data throughout a busy period, to show that offers outside idle are not taken.

// File: rtl/phash_pkg.sv
package phash_pkg;

    localparam int WORD_W    = 32;
    localparam int ROUNDS    = 64;
    localparam int BLK_WORDS = 16;
    localparam int DIG_WORDS = 8;
    localparam int MSG_BITS  = BLK_WORDS * WORD_W;
    localparam int DIG_BITS  = DIG_WORDS * WORD_W;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int PRIME_CAP = 400;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t word_tab_t [ROUNDS];

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wvars_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS1 = 3'd1,
        ST_FOLD1 = 3'd2,
        ST_PASS2 = 3'd3,
        ST_FOLD2 = 3'd4
    } phase_e;

    localparam wvars_t IV = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t e, input word_t f, input word_t g);
        return ((f ^ g) & e) ^ g;
    endfunction

    function automatic word_t major(input word_t a, input word_t b, input word_t c);
        return ((a | c) & b) | (a & c);
    endfunction

    function automatic word_t bswap32(input word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic wvars_t add_vars(input wvars_t x, input wvars_t y);
        wvars_t r;
        r.a = x.a + y.a;
        r.b = x.b + y.b;
        r.c = x.c + y.c;
        r.d = x.d + y.d;
        r.e = x.e + y.e;
        r.f = x.f + y.f;
        r.g = x.g + y.g;
        r.h = x.h + y.h;
        return r;
    endfunction

    // Digest word j leaves byte-swapped on bits 32j+31..32j.
    function automatic logic [DIG_BITS-1:0] emit_digest(input wvars_t v);
        logic [DIG_BITS-1:0] r;
        word_t lst [DIG_WORDS];
        lst = '{v.a, v.b, v.c, v.d, v.e, v.f, v.g, v.h};
        for (int j = 0; j < DIG_WORDS; j++) begin
            r[j*WORD_W +: WORD_W] = bswap32(lst[j]);
        end
        return r;
    endfunction

    function automatic bit is_prime(input int n);
        bit ok;
        ok = 1'b1;
        for (int d = 2; d * d <= n; d++) begin
            if (n % d == 0) ok = 1'b0;
        end
        return ok;
    endfunction

    // Fraction bits of the cube root of p, by bitwise search.
    function automatic word_t cbrt_frac(input int p);
        logic [127:0] target;
        logic [127:0] y;
        logic [127:0] cand;
        target = 128'(p) << 96;
        y = '0;
        for (int b = 35; b >= 0; b--) begin
            cand = y | (128'd1 << b);
            if (cand * cand * cand <= target) y = cand;
        end
        return y[WORD_W-1:0];
    endfunction

    function automatic word_tab_t build_k();
        word_tab_t t;
        int found;
        found = 0;
        for (int n = 2; n < PRIME_CAP; n++) begin
            if (found < ROUNDS && is_prime(n)) begin
                t[found] = cbrt_frac(n);
                found++;
            end
        end
        return t;
    endfunction

    // Constant plus schedule word for the fixed final block of a 512-bit message.
    function automatic word_tab_t build_pad(input word_tab_t k);
        word_tab_t t;
        word_t w [ROUNDS];
        for (int i = 0; i < ROUNDS; i++) begin
            if (i == 0)
                w[i] = 32'h8000_0000;
            else if (i == BLK_WORDS - 1)
                w[i] = word_t'(MSG_BITS);
            else if (i < BLK_WORDS)
                w[i] = '0;
            else
                w[i] = w[i-16] + w[i-7] + sml_sig0(w[i-15]) + sml_sig1(w[i-2]);
            t[i] = k[i] + w[i];
        end
        return t;
    endfunction

    localparam word_tab_t K_TAB   = build_k();
    localparam word_tab_t PAD_TAB = build_pad(K_TAB);

endpackage

// File: rtl/phash_sched.sv
module phash_sched
    import phash_pkg::*;
#(
    parameter int N_WORDS = BLK_WORDS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      shift,
    input  logic [N_WORDS*WORD_W-1:0] blk,
    output word_t                     w_now
);
    localparam int TAP_S0  = 1;
    localparam int TAP_ADD = N_WORDS - 7;
    localparam int TAP_S1  = N_WORDS - 2;

    word_t win [N_WORDS];
    word_t w_new;

    assign w_new = win[0] + win[TAP_ADD] + sml_sig0(win[TAP_S0]) + sml_sig1(win[TAP_S1]);
    assign w_now = win[0];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_slot
        word_t fill;
        if (i == N_WORDS - 1) begin : g_tail
            assign fill = w_new;
        end else begin : g_body
            assign fill = win[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)
                win[i] <= '0;
            else if (load)
                win[i] <= bswap32(blk[i*WORD_W +: WORD_W]);
            else if (shift)
                win[i] <= fill;
        end
    end
endmodule

// File: rtl/phash_round.sv
module phash_round
    import phash_pkg::*;
(
    input  wvars_t cur,
    input  word_t  kw,
    output wvars_t nxt
);
    word_t t_sum;

    assign t_sum = cur.h + big_sig1(cur.e) + choose(cur.e, cur.f, cur.g) + kw;

    always_comb begin
        nxt.a = t_sum + big_sig0(cur.a) + major(cur.a, cur.b, cur.c);
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t_sum;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/phash_kw.sv
module phash_kw
    import phash_pkg::*;
(
    input  logic             pad_pass,
    input  logic [RND_W-1:0] idx,
    input  word_t            w_msg,
    output word_t            kw
);
    assign kw = pad_pass ? PAD_TAB[idx] : (K_TAB[idx] + w_msg);
endmodule

// File: rtl/pair_digest256.sv
module pair_digest256
    import phash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MSG_BITS-1:0] in_msg,
    output logic                out_valid,
    output logic [DIG_BITS-1:0] out_digest
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    phase_e           phase;
    logic [RND_W-1:0] rnd;
    wvars_t           vars;
    wvars_t           mid;
    wvars_t           vars_nxt;
    word_t            w_msg;
    word_t            kw;
    logic             take;

    assign in_ready = (phase == ST_IDLE);
    assign take     = in_valid && in_ready;

    phash_sched #(.N_WORDS(BLK_WORDS)) u_sched (
        .clk   (clk),
        .rst   (rst),
        .load  (take),
        .shift (phase == ST_PASS1),
        .blk   (in_msg),
        .w_now (w_msg)
    );

    phash_kw u_kw (
        .pad_pass (phase == ST_PASS2),
        .idx      (rnd),
        .w_msg    (w_msg),
        .kw       (kw)
    );

    phash_round u_round (
        .cur (vars),
        .kw  (kw),
        .nxt (vars_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            rnd        <= '0;
            vars       <= '0;
            mid        <= '0;
            out_valid  <= 1'b0;
            out_digest <= '0;
        end else begin
            out_valid <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (in_valid) begin
                        vars  <= IV;
                        rnd   <= '0;
                        phase <= ST_PASS1;
                    end
                end
                ST_PASS1: begin
                    vars <= vars_nxt;
                    rnd  <= rnd + 1'b1;
                    if (rnd == LAST_RND) phase <= ST_FOLD1;
                end
                ST_FOLD1: begin
                    mid   <= add_vars(vars, IV);
                    vars  <= add_vars(vars, IV);
                    rnd   <= '0;
                    phase <= ST_PASS2;
                end
                ST_PASS2: begin
                    vars <= vars_nxt;
                    rnd  <= rnd + 1'b1;
                    if (rnd == LAST_RND) phase <= ST_FOLD2;
                end
                ST_FOLD2: begin
                    out_digest <= emit_digest(add_vars(vars, mid));
                    out_valid  <= 1'b1;
                    phase      <= ST_IDLE;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pair_digest256_chk.sv
module pair_digest256_chk
    import phash_pkg::*;
#(
    parameter int LAT = 2 * ROUNDS + 3
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic [DIG_BITS-1:0] out_digest
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (in_valid && in_ready)
            since <= CW'(1);
        else if (since != '0 && since != CW'(LAT))
            since <= since + 1'b1;
        else
            since <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r2_busy_in_flight: assert property (@(posedge clk) disable iff (rst)
        (since != '0 && since != CW'(LAT)) |-> !in_ready);

    a_r3_done_on_time: assert property (@(posedge clk) disable iff (rst)
        (since == CW'(LAT)) |-> out_valid);

    a_r3_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since == CW'(LAT)));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r8_ready_at_done: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    a_r7_digest_hold: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_digest));
endmodule

bind pair_digest256 pair_digest256_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_digest (out_digest)
);

// File: tb/pair_digest256_test.sv
`timescale 1ns/1ps
module pair_digest256_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_msg = '0;
    logic         out_valid;
    logic [255:0] out_digest;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] kk [64];
    logic [31:0] iv [8];

    always #2.5 clk = ~clk;

    pair_digest256 uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_msg     (in_msg),
        .out_valid  (out_valid),
        .out_digest (out_digest)
    );

    // ---------------- reference model ----------------
    function automatic bit tb_prime(input int n);
        bit ok = 1'b1;
        for (int d = 2; d * d <= n; d++) if (n % d == 0) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [31:0] tb_root_frac(input int p, input int pw);
        logic [127:0] tgt, y, c, pr;
        tgt = 128'(p) << (32 * pw);
        y = '0;
        for (int b = 35; b >= 0; b--) begin
            c = y | (128'd1 << b);
            pr = (pw == 3) ? c * c * c : c * c;
            if (pr <= tgt) y = c;
        end
        return y[31:0];
    endfunction

    task automatic init_consts();
        int n = 0;
        for (int p = 2; n < 64; p++) begin
            if (tb_prime(p)) begin
                kk[n] = tb_root_frac(p, 3);
                if (n < 8) iv[n] = tb_root_frac(p, 2);
                n++;
            end
        end
    endtask

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] tb_compress(input logic [255:0] hin, input logic [511:0] blk);
        logic [31:0] w [64];
        logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
        {a, b, c, d, e, f, g, h} = hin;
        for (int i = 0; i < 64; i++) begin
            t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + kk[i] + w[i];
            t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = d + t1;
            d = c; c = b; b = a; a = t1 + t2;
        end
        return {a + hin[255:224], b + hin[223:192], c + hin[191:160], d + hin[159:128],
                e + hin[127:96],  f + hin[95:64],   g + hin[63:32],   h + hin[31:0]};
    endfunction

    function automatic logic [255:0] be2lane(input logic [255:0] be);
        logic [255:0] r;
        for (int k = 0; k < 32; k++) r[8*k +: 8] = be[255-8*k -: 8];
        return r;
    endfunction

    function automatic logic [255:0] ref_digest(input logic [511:0] m);
        logic [511:0] b1, b2;
        logic [255:0] h;
        for (int k = 0; k < 64; k++) b1[511-8*k -: 8] = m[8*k +: 8];
        b2 = {8'h80, 440'd0, 64'd512};
        h = {iv[0], iv[1], iv[2], iv[3], iv[4], iv[5], iv[6], iv[7]};
        h = tb_compress(tb_compress(h, b1), b2);
        return be2lane(h);
    endfunction

    function automatic logic [511:0] rand_msg();
        logic [511:0] m;
        for (int k = 0; k < 16; k++) m[32*k +: 32] = $urandom();
        return m;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic [511:0] m);
        int guard = 0;
        while (!in_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        in_msg   = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Called at the negedge right after the taking edge.
    task automatic wait_result(input logic [511:0] m, input bit junk, input bit chain,
                               input logic [511:0] nxt, input string tag);
        int n = 0;
        bit rdy_low = 1'b1;
        logic [255:0] exp, held;
        exp = ref_digest(m);
        while (!out_valid && n < 1000) begin
            if (in_ready !== 1'b0) rdy_low = 1'b0;
            if (junk && n < 100) begin
                in_valid = 1'b1;
                in_msg   = rand_msg();
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check(rdy_low, {"R2 ready low while busy ", tag}, 256'(in_ready), 256'd0);
        check(n == 130, {"R3 latency ", tag}, 256'(n), 256'd130);
        check(out_digest === exp, {"R5 digest ", tag}, out_digest, exp);
        if (junk) check(out_digest === exp, {"R6 busy offers ignored ", tag}, out_digest, exp);
        held = out_digest;
        if (chain) begin
            check(in_ready === 1'b1, {"R8 ready with done ", tag}, 256'(in_ready), 256'd1);
            in_msg   = nxt;
            in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b0, {"R4 single pulse ", tag}, 256'(out_valid), 256'd0);
        check(out_digest === held, {"R7 digest held ", tag}, out_digest, held);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [511:0] m, m2;
        logic [255:0] kat;
        void'($urandom(32'd1357911));
        init_consts();

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready after reset", 256'(in_ready), 256'd1);
        check(out_valid === 1'b0, "R1 valid low after reset", 256'(out_valid), 256'd0);
        check(out_digest === '0, "R1 digest cleared", out_digest, 256'd0);

        // zero message, also against a known answer
        m = '0;
        kat = be2lane(256'hf5a5fd42d16a20302798ef6ed309979b43003d2320d9f0e8ea9831a92759fb4b);
        start(m);
        wait_result(m, 1'b0, 1'b0, '0, "zeros");
        check(out_digest === kat, "R5 known answer zeros", out_digest, kat);

        // ascending bytes 0x00..0x3f
        for (int k = 0; k < 64; k++) m[8*k +: 8] = 8'(k);
        start(m);
        wait_result(m, 1'b0, 1'b0, '0, "ascending");

        // all ones
        m = '1;
        start(m);
        wait_result(m, 1'b0, 1'b0, '0, "ones");

        // R6: offers with changing data during the busy period
        m = rand_msg();
        start(m);
        wait_result(m, 1'b1, 1'b0, '0, "busy offers");

        // R8: chained requests taken in the done cycle
        m  = rand_msg();
        m2 = rand_msg();
        start(m);
        wait_result(m, 1'b0, 1'b1, m2, "chain first");
        wait_result(m2, 1'b0, 1'b0, '0, "chain second");

        // random messages
        for (int r = 0; r < 5; r++) begin
            m = rand_msg();
            start(m);
            wait_result(m, 1'b0, 1'b0, '0, "random");
        end

        // R9: reset in the middle of a hash
        m = rand_msg();
        start(m);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R9 ready after abort", 256'(in_ready), 256'd1);
        check(out_digest === '0, "R9 digest cleared by abort", out_digest, 256'd0);
        begin
            bit stray = 1'b0;
            for (int c = 0; c < 200; c++) begin
                if (out_valid !== 1'b0) stray = 1'b1;
                @(negedge clk);
            end
            check(!stray, "R9 no result after abort", 256'(stray), 256'd0);
        end
        m = rand_msg();
        start(m);
        wait_result(m, 1'b0, 1'b0, '0, "R9 after abort");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule